// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim among a fixed set of physical page frames with the circular second-chance (clock) policy. Each frame carries a use flag and a lock flag. Page references and page loads raise a frame's use flag. Lock and unlock commands raise or drop its lock flag. A rotating hand remembers where the last search stopped.

A victim request starts a search at the hand, one frame per clock. A locked frame is stepped over and its flags are left alone. An unlocked frame whose use flag is set loses the flag and is stepped over. The first unlocked frame with a clear use flag is chosen, and the hand moves to the frame after it. If two full turns find nothing, which can only happen when every frame is locked, the search reports that no victim exists.

The controller has three states. IDLE waits; the transition IDLE→SCAN is taken on a request. SCAN examines the frame under the hand each cycle. It takes SCAN→REPORT when a victim is found or when the 2N-th examination finds none, and otherwise stays in SCAN. REPORT drives the one-cycle result and always takes REPORT→IDLE.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset the hand points at frame 0, every use and lock flag is 0, and `busy`, `done` and `no_victim` are 0; the first request after reset returns frame 0 after one examination.
- R2: A cycle with `ref_valid` or `load_valid` high sets the use flag of frame `ref_idx` or `load_idx`, and both ports have the same effect.
- R3: `lock_valid` sets the lock flag of frame `lock_idx`, `unlock_valid` clears the lock flag of frame `unlock_idx`, and a frame whose lock flag is set is never returned as the victim.
- R4: A search examines one frame per clock, starting at the hand and going upward, with frame N-1 followed by frame 0. If the request is sampled at clock edge k and j frames are examined, `done` is high for exactly the one cycle after edge k+j.
- R5: When the search steps over an unlocked frame whose use flag is 1, it clears that flag. Stepping over a locked frame changes none of its flags.
- R6: The victim is the first unlocked frame examined whose use flag is 0. `victim_idx` carries it while `done` is high, and the hand then points at the next frame modulo N.
- R7: When 2N examinations find no victim, `done` and `no_victim` are high together, and the hand is back where the search started.
- R8: A reference or load to the frame under examination in that same cycle makes the frame count as used, and its use flag stays 1 rather than being cleared.
- R9: `busy` is high from the cycle after an accepted request through the `done` cycle and low in the cycle after it. A request while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Page reference strobe |
| ref_idx | input | IDXW | Frame referenced |
| load_valid | input | 1 | Page load strobe |
| load_idx | input | IDXW | Frame loaded |
| lock_valid | input | 1 | Lock strobe |
| lock_idx | input | IDXW | Frame to lock |
| unlock_valid | input | 1 | Unlock strobe |
| unlock_idx | input | IDXW | Frame to unlock |
| req | input | 1 | Victim request, taken only when not busy |
| busy | output | 1 | Search in progress or result being shown |
| done | output | 1 | One-cycle result strobe |
| victim_idx | output | IDXW | Chosen frame, valid with `done` |
| no_victim | output | 1 | High with `done` when every frame was locked |

## Verification
The result of a search is due exactly j cycles after the request edge, where j is the number of frames a search following the requirements would examine. The bench derives j, the victim and the no-victim flag from its own model of the use flags, lock flags and hand. It samples on falling edges and counts falling edges after the request, so the measured latency must equal j. A one-cycle error or a wrong pass order shows up as a miscompare. Commands that update flags are applied one per cycle and take effect at the next rising edge. The exception is a reference to the frame under the hand, which the bench times to fall in the first examination cycle.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } clkrep_state_e;
endpackage

// File: rtl/clkrep_frame_bits.sv
module clkrep_frame_bits #(
    parameter int NFRAMES = 16,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_valid,
    input  logic [IDXW-1:0]    ref_idx,
    input  logic               load_valid,
    input  logic [IDXW-1:0]    load_idx,
    input  logic               lock_valid,
    input  logic [IDXW-1:0]    lock_idx,
    input  logic               unlock_valid,
    input  logic [IDXW-1:0]    unlock_idx,
    input  logic               clr_en,
    input  logic [IDXW-1:0]    clr_idx,
    output logic [NFRAMES-1:0] use_vec,
    output logic [NFRAMES-1:0] lock_vec
);
    for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
        logic use_q;
        logic lock_q;
        logic set_use;
        assign set_use = (ref_valid && ref_idx == IDXW'(i)) ||
                         (load_valid && load_idx == IDXW'(i));

        // a set in the same cycle beats the scan's clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                use_q <= 1'b0;
            else if (set_use)                          use_q <= 1'b1;
            else if (clr_en && clr_idx == IDXW'(i))    use_q <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       lock_q <= 1'b0;
            else if (lock_valid && lock_idx == IDXW'(i))      lock_q <= 1'b1;
            else if (unlock_valid && unlock_idx == IDXW'(i))  lock_q <= 1'b0;
        end

        assign use_vec[i]  = use_q;
        assign lock_vec[i] = lock_q;
    end
endmodule

// File: rtl/clkrep_hand.sv
module clkrep_hand #(
    parameter int NFRAMES = 16,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] hand
);
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NFRAMES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hand <= '0;
        else if (adv)      hand <= (hand == TOP_IDX) ? '0 : hand + 1'b1;
    end
endmodule

// File: rtl/clkrep_fsm.sv
module clkrep_fsm
    import clkrep_pkg::*;
#(
    parameter int NFRAMES = 16,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            cur_use,
    input  logic            cur_lock,
    input  logic [IDXW-1:0] hand,
    output logic            adv,
    output logic            clr_en,
    output logic            busy,
    output logic            done,
    output logic            no_victim,
    output logic [IDXW-1:0] victim_idx
);
    localparam int STEPW = $clog2(2 * NFRAMES);
    localparam logic [STEPW-1:0] LAST_STEP = STEPW'(2 * NFRAMES - 1);

    clkrep_state_e   state_q, state_d;
    logic [STEPW-1:0] step_q, step_d;
    logic [IDXW-1:0]  victim_q, victim_d;
    logic             nv_q, nv_d;

    // next-state and scan control
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        victim_d = victim_q;
        nv_d     = nv_q;
        adv      = 1'b0;
        clr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_SCAN;
                    step_d  = '0;
                end
            end
            ST_SCAN: begin
                adv    = 1'b1;
                step_d = step_q + 1'b1;
                if (!cur_lock && !cur_use) begin
                    victim_d = hand;
                    nv_d     = 1'b0;
                    state_d  = ST_REPORT;
                end else begin
                    clr_en = !cur_lock;
                    if (step_q == LAST_STEP) begin
                        nv_d    = 1'b1;
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            victim_q <= '0;
            nv_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            step_q   <= step_d;
            victim_q <= victim_d;
            nv_q     <= nv_d;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_REPORT);
        no_victim  = (state_q == ST_REPORT) && nv_q;
        victim_idx = victim_q;
    end
endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
    parameter int NFRAMES = 16,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_valid,
    input  logic [IDXW-1:0] ref_idx,
    input  logic            load_valid,
    input  logic [IDXW-1:0] load_idx,
    input  logic            lock_valid,
    input  logic [IDXW-1:0] lock_idx,
    input  logic            unlock_valid,
    input  logic [IDXW-1:0] unlock_idx,
    input  logic            req,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] victim_idx,
    output logic            no_victim
);
    logic [NFRAMES-1:0] use_vec;
    logic [NFRAMES-1:0] lock_vec;
    logic [IDXW-1:0]    hand;
    logic               adv;
    logic               clr_en;
    logic               cur_use;
    logic               cur_lock;

    // a same-cycle reference or load to the frame under the hand counts as use
    assign cur_use  = use_vec[hand] ||
                      (ref_valid && ref_idx == hand) ||
                      (load_valid && load_idx == hand);
    assign cur_lock = lock_vec[hand];

    clkrep_frame_bits #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_idx(ref_idx),
        .load_valid(load_valid), .load_idx(load_idx),
        .lock_valid(lock_valid), .lock_idx(lock_idx),
        .unlock_valid(unlock_valid), .unlock_idx(unlock_idx),
        .clr_en(clr_en), .clr_idx(hand),
        .use_vec(use_vec), .lock_vec(lock_vec)
    );

    clkrep_hand #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_hand (
        .clk(clk), .rst_n(rst_n), .adv(adv), .hand(hand)
    );

    clkrep_fsm #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req),
        .cur_use(cur_use), .cur_lock(cur_lock), .hand(hand),
        .adv(adv), .clr_en(clr_en),
        .busy(busy), .done(done), .no_victim(no_victim),
        .victim_idx(victim_idx)
    );
endmodule

// File: rtl/clkrep_checker.sv
module clkrep_checker #(
    parameter int NFRAMES = 16,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               busy,
    input logic               done,
    input logic               no_victim,
    input logic [IDXW-1:0]    victim_idx,
    input logic [IDXW-1:0]    hand,
    input logic [NFRAMES-1:0] lock_vec
);
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NFRAMES - 1);

    logic [NFRAMES-1:0] lock_prev;
    logic [IDXW-1:0]    hand_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_prev <= '0;
        else        lock_prev <= lock_vec;
    end
    assign hand_next = (victim_idx == TOP_IDX) ? '0 : victim_idx + 1'b1;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R4
    AST_NV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim |-> done);                                       // R7
    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_victim) |-> !lock_prev[victim_idx]);          // R3
    AST_HAND_AFTER_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_victim) |-> hand == hand_next);               // R6
    AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);                                  // R9
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                           // R9
endmodule

bind clock_victim_picker clkrep_checker #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
    .no_victim(no_victim), .victim_idx(victim_idx), .hand(hand),
    .lock_vec(lock_vec)
);

// File: tb/clock_victim_picker_bench.sv
`timescale 1ns/1ps
module clock_victim_picker_bench;
    localparam int N  = 16;
    localparam int IW = 4;
    localparam int NVEC = 9;

    // stimulus table: lock mask and use mask applied before one search
    localparam logic [N-1:0] TBL_LOCK [NVEC] = '{
        16'h0000, 16'h0000, 16'h00FF, 16'hFFFF, 16'h7FFF,
        16'h0000, 16'h8001, 16'hF0F0, 16'h0000 };
    localparam logic [N-1:0] TBL_USE [NVEC] = '{
        16'h0000, 16'hFFFF, 16'h0F0F, 16'h0000, 16'hFFFF,
        16'hAAAA, 16'h5555, 16'hFFFF, 16'h0000 };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_valid = 1'b0, load_valid = 1'b0, lock_valid = 1'b0, unlock_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0, load_idx = '0, lock_idx = '0, unlock_idx = '0;
    logic req = 1'b0;
    logic busy, done, no_victim;
    logic [IW-1:0] victim_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit use_m [N];
    bit lock_m [N];
    int hand_m = 0;

    always #10 clk = ~clk;

    clock_victim_picker #(.NFRAMES(N), .IDXW(IW)) u_clock_victim_picker (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_idx(ref_idx),
        .load_valid(load_valid), .load_idx(load_idx),
        .lock_valid(lock_valid), .lock_idx(lock_idx),
        .unlock_valid(unlock_valid), .unlock_idx(unlock_idx),
        .req(req), .busy(busy), .done(done),
        .victim_idx(victim_idx), .no_victim(no_victim)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // R3 R2: lock flags by mask, then set use flags (refs on even frames, loads on odd)
    task automatic setup(input logic [N-1:0] lmask, input logic [N-1:0] umask);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            lock_valid   = lmask[i];
            unlock_valid = !lmask[i];
            lock_idx     = IW'(i);
            unlock_idx   = IW'(i);
            lock_m[i]    = lmask[i];
        end
        @(negedge clk);
        lock_valid = 1'b0; unlock_valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (umask[i]) begin
                if (i % 2 == 0) begin ref_valid = 1'b1; ref_idx = IW'(i); end
                else            begin load_valid = 1'b1; load_idx = IW'(i); end
                use_m[i] = 1'b1;
                @(negedge clk);
                ref_valid = 1'b0; load_valid = 1'b0;
            end
        end
    endtask

    task automatic run_scan(input string tag, input bit ref_first, input bit req_again);
        int  h = hand_m;
        int  start = hand_m;
        int  exp_v = 0;
        bit  exp_nv = 1'b1;
        int  exp_cyc = 2 * N;
        bit  found = 1'b0;
        int  cnt = 0;
        for (int s = 0; s < 2 * N; s++) begin
            if (!found) begin
                if (!lock_m[h]) begin
                    if (s == 0 && ref_first) use_m[h] = 1'b1;        // R8
                    else if (use_m[h]) use_m[h] = 1'b0;              // R5
                    else begin
                        found = 1'b1; exp_v = h; exp_nv = 1'b0; exp_cyc = s + 1;
                    end
                end
                h = (h + 1) % N;
            end
        end
        hand_m = found ? (exp_v + 1) % N : start;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (ref_first) begin ref_valid = 1'b1; ref_idx = IW'(start); end
        while (!done && cnt < 4 * N) begin
            @(negedge clk);
            cnt++;
            ref_valid = 1'b0;
            req = (req_again && cnt == 2);
        end
        req = 1'b0;
        check(cnt == exp_cyc, {tag, " R4 latency"}, cnt, exp_cyc);
        check(no_victim == exp_nv, {tag, " R7 no_victim"}, int'(no_victim), int'(exp_nv));
        if (!exp_nv)
            check(int'(victim_idx) == exp_v, {tag, " R6 victim"}, int'(victim_idx), exp_v);
        if (req_again) begin
            @(negedge clk);
            check(!busy && !done, {tag, " R9 idle after done, retrigger ignored"},
                  int'({busy, done}), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin use_m[i] = 1'b0; lock_m[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !no_victim, "R1 reset outputs", int'({busy, done, no_victim}), 0);
        check(victim_idx == '0, "R1 reset victim_idx", int'(victim_idx), 0);
        // R1: first search after reset finds frame 0 in one cycle
        run_scan("R1 first", 1'b0, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            setup(TBL_LOCK[v], TBL_USE[v]);
            run_scan($sformatf("vec%0d R2 R3 R5", v), 1'b0, 1'b0);
        end

        // R8: reference to the frame under the hand in the first examined cycle
        setup('0, '1);
        run_scan("R8 same-cycle ref", 1'b1, 1'b0);

        // R9: second request during a search is ignored
        setup('0, '1);
        run_scan("R9 busy", 1'b0, 1'b1);

        // R7: every frame locked, use flags preserved after unlock (R5)
        setup('1, '1);
        run_scan("R7 all locked", 1'b0, 1'b0);
        setup('0, '0);
        run_scan("R5 flags kept", 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule